// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hardware Averaging

This block is the digital control around an external successive-approximation converter core. A write of a channel code starts one conversion on that channel. The conversion opens with a fixed setup interval. After that comes one slot per averaged sample. Each slot has a programmable sampling window followed by a fixed base conversion time. The block drives a one-cycle start strobe and a sampling strobe to the core. It captures the core's raw result at the end of every slot and publishes the average of the captured samples as one result. All timing is counted in converter-clock ticks, which a power-of-two divider derives from the bus clock.

The configuration inputs are sampled when a conversion starts and held until it ends. A continuous mode restarts the sequence on the same channel as soon as a result completes. A dedicated stop code ends any activity. An overwrite control decides whether a fresh result may replace one that has not been read yet.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy_o, done_o, valid_o, core_start_o and core_sample_o are 0 and result_o is 0.
- R2: A conversion lasts T = 6 + N*(25 + L) converter ticks, and each tick is D bus cycles. If chan_wr_i is sampled at edge E0, done_o is high in the cycle after edge E0 + T*D.
- R3: The sampling window L is 3 + 2*long_sel_i ticks when long_en_i is 0, giving 3, 5, 7 or 9. It is 13 + 4*long_sel_i ticks when long_en_i is 1, giving 13, 17, 21 or 25.
- R4: N is 1 when avg_en_i is 0 and 4 << avg_sel_i (4, 8, 16 or 32) when avg_en_i is 1. result_o equals the sum of the N captured samples shifted right by log2(N), with no accumulator overflow.
- R5: D = 2^(clk_div_i + half_src_i). clk_div_i values 0 to 3 give divide-by 1, 2, 4 and 8. Setting half_src_i together with clk_div_i = 3 gives divide-by-16.
- R6: res_mode_i 0 keeps raw bits [7:0], 1 keeps bits [9:0], and 2 or 3 keeps bits [11:0]. The masking is applied to every captured sample, so unused upper result bits are zero.
- R7: A chan_wr_i with chan_i = 0x1F clears busy_o at the next edge and abandons the running conversion, which produces no result. Any other code starts a conversion on that channel and restarts one that is already running.
- R8: With cont_i set at start, a new conversion on the same channel begins at the completing edge, so the next done_o follows exactly T*D cycles later.
- R9: A completed result is stored only if valid_o is 0, ovw_en_i is 1, or read_i is high in that cycle. Otherwise it is discarded, and result_o, valid_o and done_o are left untouched. read_i clears valid_o.
- R10: core_start_o is a one-cycle pulse at the start of each sample slot, N pulses per conversion. core_sample_o is high for L*D cycles per slot. core_chan_o carries the channel.
- R11: Configuration inputs changed after the start edge do not affect the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_wr_i | input | 1 | Channel-code write strobe |
| chan_i | input | 5 | Channel code; 0x1F stops |
| cont_i | input | 1 | Continuous restart mode |
| res_mode_i | input | 2 | Resolution select |
| clk_div_i | input | 2 | Converter clock divider exponent |
| half_src_i | input | 1 | Half-bus-clock source (extra divide-by-2) |
| long_en_i | input | 1 | Long sampling window enable |
| long_sel_i | input | 2 | Sampling window extension select |
| avg_en_i | input | 1 | Hardware averaging enable |
| avg_sel_i | input | 2 | Averaging count select |
| ovw_en_i | input | 1 | Allow overwrite of an unread result |
| read_i | input | 1 | Result read acknowledge |
| core_data_i | input | 12 | Raw result from the converter core |
| core_start_o | output | 1 | Sample slot start strobe to the core |
| core_sample_o | output | 1 | Sampling window strobe to the core |
| core_chan_o | output | 5 | Channel presented to the core |
| busy_o | output | 1 | Conversion sequence active |
| done_o | output | 1 | One-cycle pulse when a result is stored |
| valid_o | output | 1 | Stored result not yet read |
| result_o | output | 12 | Averaged, masked result |

## Verification
The bench builds the block with its default parameters: a 5-bit channel code, a 12-bit result, averaging up to 32 samples and a divide exponent up to 4. With these defaults the largest accumulator sum and the divide-by-16 path can both be reached. One directed run uses the longest window, 32 samples and divide-by-16, which fills the accumulator close to its limit. The random runs keep the divider at 4 or below so that many window, count and resolution combinations fit in the time budget.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SETUP_TICKS = 6;
  localparam int BASE_TICKS  = 25;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_SAMPLE, PH_CONV} phase_e;

  // sampling window length in converter ticks
  function automatic logic [4:0] lsa_ticks(input logic long_en, input logic [1:0] sel);
    return long_en ? (5'd13 + {1'b0, sel, 2'b00}) : (5'd3 + {2'b00, sel, 1'b0});
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_LOG2_MAX = 4,
  localparam int DIV_W = $clog2(DIV_LOG2_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_log2_i,
  output logic             tick_o
);
  logic [DIV_LOG2_MAX-1:0] cnt_q;
  logic [DIV_LOG2_MAX:0]   lim;

  assign lim    = ({{DIV_LOG2_MAX{1'b0}}, 1'b1} << div_log2_i) - 1'b1;
  assign tick_o = run_i && ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i || tick_o || !run_i)   cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  a_r5_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (div_log2_i != '0) && !clr_i |=> !tick_o);
endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl import adc_seq_pkg::*; #(
  parameter int AVG_LOG2_MAX = 5,
  localparam int NAV_W = $clog2(AVG_LOG2_MAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    tick_i,
  input  logic                    cont_i,
  input  logic [4:0]              lsa_i,
  input  logic [NAV_W-1:0]        navg_log2_i,
  output logic                    busy_o,
  output logic                    core_start_o,
  output logic                    core_sample_o,
  output logic                    capture_o,
  output logic                    last_o
);
  phase_e                  ph_q;
  logic [4:0]              cnt_q;
  logic [AVG_LOG2_MAX-1:0] idx_q;
  logic [AVG_LOG2_MAX-1:0] idx_last;
  logic                    hold;
  logic                    setup_end;
  logic                    strobe_d;

  assign hold      = start_i || stop_i;
  assign idx_last  = ~({AVG_LOG2_MAX{1'b1}} << navg_log2_i);
  assign setup_end = tick_i && (ph_q == PH_SETUP) && (cnt_q == 5'(SETUP_TICKS - 1));
  assign capture_o = !hold && tick_i && (ph_q == PH_CONV) && (cnt_q == 5'(BASE_TICKS - 1));
  assign last_o    = capture_o && (idx_q == idx_last);
  assign strobe_d  = !hold && (setup_end || (capture_o && !last_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0;
    end else if (start_i) begin
      ph_q <= PH_SETUP; cnt_q <= '0; idx_q <= '0;
    end else if (stop_i) begin
      ph_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0;
    end else if (tick_i) begin
      unique case (ph_q)
        PH_SETUP: begin
          if (setup_end) begin ph_q <= PH_SAMPLE; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_SAMPLE: begin
          if (cnt_q == lsa_i - 5'd1) begin ph_q <= PH_CONV; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_CONV: begin
          if (capture_o) begin
            cnt_q <= '0;
            if (last_o) begin
              idx_q <= '0;
              ph_q  <= cont_i ? PH_SETUP : PH_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              ph_q  <= PH_SAMPLE;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) core_start_o <= 1'b0;
    else         core_start_o <= strobe_d;
  end

  assign busy_o        = (ph_q != PH_IDLE);
  assign core_sample_o = (ph_q == PH_SAMPLE);

  a_r10_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  a_r10_sample_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_sample_o |-> busy_o);
  a_r7_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !busy_o && !core_sample_o);
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
  parameter int RES_W        = 12,
  parameter int AVG_LOG2_MAX = 5,
  localparam int ACC_W = RES_W + AVG_LOG2_MAX,
  localparam int NAV_W = $clog2(AVG_LOG2_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             capture_i,
  input  logic             last_i,
  input  logic [RES_W-1:0] data_i,
  input  logic [NAV_W-1:0] navg_log2_i,
  output logic [RES_W-1:0] avg_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_w;

  assign sum_w = acc_q + ACC_W'(data_i);
  assign avg_o = RES_W'(sum_w >> navg_log2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (clr_i)     acc_q <= '0;
    else if (capture_i) acc_q <= last_i ? '0 : sum_w;
  end

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i && !last_i && !clr_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top import adc_seq_pkg::*; #(
  parameter int CH_W         = 5,
  parameter int RES_W        = 12,
  parameter int AVG_LOG2_MAX = 5,
  parameter int DIV_LOG2_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_wr_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             cont_i,
  input  logic [1:0]       res_mode_i,
  input  logic [1:0]       clk_div_i,
  input  logic             half_src_i,
  input  logic             long_en_i,
  input  logic [1:0]       long_sel_i,
  input  logic             avg_en_i,
  input  logic [1:0]       avg_sel_i,
  input  logic             ovw_en_i,
  input  logic             read_i,
  input  logic [RES_W-1:0] core_data_i,
  output logic             core_start_o,
  output logic             core_sample_o,
  output logic [CH_W-1:0]  core_chan_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  localparam int DIV_W = $clog2(DIV_LOG2_MAX + 1);
  localparam int NAV_W = $clog2(AVG_LOG2_MAX + 1);

  logic             start_w, stop_w, tick_w, capture_w, last_w, store_w;
  logic [CH_W-1:0]  chan_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       lsa_q;
  logic [NAV_W-1:0] navg_q;
  logic [1:0]       res_q;
  logic             cont_q;
  logic [RES_W-1:0] res_mask, data_m, avg_w;

  assign start_w = chan_wr_i && (chan_i != '1);
  assign stop_w  = chan_wr_i && (chan_i == '1);

  // configuration is frozen for the whole sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0; div_q <= '0; lsa_q <= 5'd3; navg_q <= '0; res_q <= '0; cont_q <= 1'b0;
    end else if (start_w) begin
      chan_q <= chan_i;
      div_q  <= DIV_W'(clk_div_i) + DIV_W'(half_src_i);
      lsa_q  <= lsa_ticks(long_en_i, long_sel_i);
      navg_q <= avg_en_i ? (NAV_W'(avg_sel_i) + NAV_W'(2)) : '0;
      res_q  <= res_mode_i;
      cont_q <= cont_i;
    end
  end

  always_comb begin
    unique case (res_q)
      2'd0:    res_mask = RES_W'(8'hFF);
      2'd1:    res_mask = RES_W'(10'h3FF);
      default: res_mask = '1;
    endcase
  end
  assign data_m = core_data_i & res_mask;

  adc_clk_div #(.DIV_LOG2_MAX(DIV_LOG2_MAX)) u_div (
    .clk_i, .rst_ni, .clr_i(start_w), .run_i(busy_o),
    .div_log2_i(div_q), .tick_o(tick_w)
  );

  adc_phase_ctrl #(.AVG_LOG2_MAX(AVG_LOG2_MAX)) u_phase (
    .clk_i, .rst_ni, .start_i(start_w), .stop_i(stop_w), .tick_i(tick_w),
    .cont_i(cont_q), .lsa_i(lsa_q), .navg_log2_i(navg_q), .busy_o,
    .core_start_o, .core_sample_o, .capture_o(capture_w), .last_o(last_w)
  );

  adc_avg_acc #(.RES_W(RES_W), .AVG_LOG2_MAX(AVG_LOG2_MAX)) u_acc (
    .clk_i, .rst_ni, .clr_i(start_w), .capture_i(capture_w), .last_i(last_w),
    .data_i(data_m), .navg_log2_i(navg_q), .avg_o(avg_w)
  );

  assign store_w = last_w && (!valid_o || ovw_en_i || read_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0; valid_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= store_w;
      if (store_w) begin
        result_o <= avg_w;
        valid_o  <= 1'b1;
      end else if (read_i) begin
        valid_o  <= 1'b0;
      end
    end
  end

  assign core_chan_o = chan_q;

  a_r9_keep_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ovw_en_i && !read_i |=> $stable(result_o) && !done_o);
  a_r6_res_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o & ~res_mask) == '0);
  a_r2_done_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic chan_wr = 0, cont = 0, half = 0, long_en = 0, avg_en = 0, ovw = 1, rd = 0;
  logic [4:0] chan = 0;
  logic [1:0] res = 2, cdiv = 0, long_sel = 0, avg_sel = 0;
  logic [11:0] core_data = 0;
  logic core_start, core_sample, busy, done, valid;
  logic [4:0] core_chan;
  logic [11:0] result;

  int checks = 0, fails = 0;
  int g_cnt = 0, tag_q = 0, dly = 0, n_start = 0, n_samp = 0;

  always #10 clk = ~clk;

  adc_seq_top dut (
    .clk_i(clk), .rst_ni, .chan_wr_i(chan_wr), .chan_i(chan), .cont_i(cont),
    .res_mode_i(res), .clk_div_i(cdiv), .half_src_i(half), .long_en_i(long_en),
    .long_sel_i(long_sel), .avg_en_i(avg_en), .avg_sel_i(avg_sel), .ovw_en_i(ovw),
    .read_i(rd), .core_data_i(core_data), .core_start_o(core_start),
    .core_sample_o(core_sample), .core_chan_o(core_chan), .busy_o(busy),
    .done_o(done), .valid_o(valid), .result_o(result)
  );

  function automatic logic [11:0] pat(input int g, input int ch);
    int v;
    v = g * 977 + ch * 389 + 123;
    return v[11:0];
  endfunction

  // core model: fixed 3-cycle latency after each slot start
  always @(posedge clk) begin
    if (core_start) begin
      tag_q <= g_cnt; g_cnt <= g_cnt + 1; dly <= 3;
    end else if (dly != 0) dly <= dly - 1;
    if (dly == 1) core_data <= pat(tag_q, int'(core_chan));
  end

  always @(negedge clk) begin
    if (core_start)  n_start++;
    if (core_sample) n_samp++;
  end

  function automatic int lsa_f(input logic en, input logic [1:0] s);
    return en ? 13 + 4 * int'(s) : 3 + 2 * int'(s);
  endfunction
  function automatic int navg_f(input logic en, input logic [1:0] s);
    return en ? (4 << s) : 1;
  endfunction
  function automatic int div_f(input logic [1:0] c, input logic h);
    return 1 << (int'(c) + int'(h));
  endfunction
  function automatic int mask_f(input logic [1:0] r);
    return (r == 0) ? 'hFF : (r == 1) ? 'h3FF : 'hFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_chan(input logic [4:0] ch);
    @(negedge clk); chan = ch; chan_wr = 1;
    @(posedge clk);
    @(negedge clk); chan_wr = 0;
  endtask

  task automatic wait_done(input int lim, output int lat);
    lat = 0;
    while (lat <= lim) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (done) return;
    end
    lat = -1;
  endtask

  task automatic pulse_read;
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  // full conversion with latency, strobe, and result checks
  task automatic conv(input logic [4:0] ch, input string req);
    int l, n, d, t, g0, s0, p0, lat, sum, m;
    l = lsa_f(long_en, long_sel); n = navg_f(avg_en, avg_sel);
    d = div_f(cdiv, half); m = mask_f(res);
    t = d * (6 + n * (25 + l));
    write_chan(ch);
    g0 = g_cnt; s0 = n_start; p0 = n_samp;
    chk(core_chan == ch, "R10 chan", int'(core_chan), int'(ch));
    wait_done(t + 40, lat);
    chk(lat == t, {req, " R2 latency"}, lat, t);
    chk(n_start - s0 == n, "R10 start pulses", n_start - s0, n);
    chk(n_samp - p0 == n * l * d, "R3 R10 sample window", n_samp - p0, n * l * d);
    sum = 0;
    for (int i = 0; i < n; i++) sum += int'(pat(g0 + i, int'(ch))) & m;
    chk(int'(result) == sum / n, {req, " R4 R6 result"}, int'(result), sum / n);
    chk(valid == 1'b1, "R9 valid", int'(valid), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat, t;
    logic [11:0] held;
    void'($urandom(32'h1234));
    repeat (4) @(negedge clk);
    chk(!busy && !done && !valid && !core_start && !core_sample, "R1 flags", int'(busy), 0);
    chk(result == 0, "R1 result", int'(result), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // directed: shortest
    res = 2; conv(5'd3, "min"); pulse_read;
    // directed: longest window, 32 samples, divide-by-16
    long_en = 1; long_sel = 3; avg_en = 1; avg_sel = 3; cdiv = 3; half = 1;
    conv(5'd9, "R5 div16 max"); pulse_read;
    half = 0;
    // resolutions
    long_en = 0; long_sel = 1; avg_en = 1; avg_sel = 0; cdiv = 1;
    res = 0; conv(5'd2, "res8");  pulse_read;
    res = 1; conv(5'd4, "res10"); pulse_read;
    res = 3; conv(5'd6, "res12 code3"); pulse_read;

    // random mix
    for (int k = 0; k < 12; k++) begin
      long_en = 1'($urandom); long_sel = 2'($urandom);
      avg_en = 1'($urandom); avg_sel = 2'($urandom);
      cdiv = 2'($urandom_range(0, 2)); res = 2'($urandom);
      conv(5'($urandom_range(0, 30)), "random"); pulse_read;
    end

    // R9: discard when unread and overwrite disabled
    long_en = 0; long_sel = 0; avg_en = 0; cdiv = 0; res = 2; ovw = 0;
    conv(5'd7, "R9 first");
    held = result;
    write_chan(5'd8);
    wait_done(34 + 20, lat);
    chk(lat == -1, "R9 no done on discard", lat, -1);
    chk(result == held, "R9 result kept", int'(result), int'(held));
    chk(valid == 1'b1, "R9 still valid", int'(valid), 1);
    ovw = 1;
    conv(5'd10, "R9 overwrite"); pulse_read;
    chk(valid == 1'b0, "R9 read clears", int'(valid), 0);

    // R7: stop mid-conversion
    avg_en = 1; avg_sel = 1;
    write_chan(5'd11);
    repeat (60) @(negedge clk);
    write_chan(5'h1F);
    chk(busy == 1'b0, "R7 stop", int'(busy), 0);
    wait_done(300, lat);
    chk(lat == -1, "R7 no result after stop", lat, -1);

    // R8: continuous mode
    avg_en = 0; cdiv = 1; cont = 1;
    t = 2 * 34;
    write_chan(5'd12);
    cont = 0;
    wait_done(t + 20, lat);
    chk(lat == t, "R8 first latency", lat, t);
    wait_done(t + 20, lat);
    chk(lat == t, "R8 restart latency", lat, t);
    chk(core_chan == 5'd12, "R8 same channel", int'(core_chan), 12);
    write_chan(5'h1F);
    chk(busy == 1'b0, "R8 R7 stop continuous", int'(busy), 0);
    pulse_read;

    // R11: config change after start has no effect
    cdiv = 0; long_en = 0; long_sel = 0; avg_en = 0;
    write_chan(5'd13);
    cdiv = 3; long_en = 1; avg_en = 1;
    wait_done(34 + 20, lat);
    chk(lat == 34, "R11 latched config", lat, 34);
    pulse_read;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule